// File: doc/BRIEF.md
# Glitch-Free Reference Clock Selector

This block picks one of two reference clocks, a primary and a secondary, and forwards it to downstream phase-detection logic on a single output clock. A free-running monitor clock watches both references for activity. A reference counts as present while it keeps producing rising edges inside a programmable timeout window. A mode input selects between manual steering and automatic failover. In manual steering an external select pin names the input. In automatic failover the primary is always preferred. The block drops to the secondary only while the primary is missing, and it goes back to the primary as soon as the primary shows activity again.

Each reference has its own gate: an enable flop chain clocked on the falling edge of that reference. A gate may open only after the other gate has been seen closed, so a change of source never cuts a pulse short and never merges pulses from the two clocks. The two references may differ in frequency by up to 20% and may have any phase relationship. A reference that stops, whether stuck low or stuck high, has its gate cleared through the activity monitor, because a stopped clock cannot close its own gate. When neither reference is present, the output is held low and a flag reports the condition.

Top module: `refclk_selector`

## Requirements
- R1: While rst_n is low, clk_out, pri_active and no_ref are all low.
- R2: With auto_mode = 0 (manual), sel_pin = 1 routes ref_pri to clk_out and sel_pin = 0 routes ref_sec, provided at least one reference is present.
- R3: With auto_mode = 1, ref_pri is routed whenever it is present, even when ref_sec is also present.
- R4: With auto_mode = 1, losing ref_pri while ref_sec is present switches clk_out to ref_sec. Once ref_pri shows activity again, clk_out switches back to ref_pri.
- R5: The two gates are break-before-make: at no time do both references reach clk_out, and the synchronized gate states are never both high.
- R6: clk_out never shows a high or low pulse shorter than the shorter half-period of the two references. This holds across every source change, including a primary that stops while high.
- R7: A reference counts as present after the monitor sees a rising edge of it. It counts as missing only after tmo_cycles monitor cycles pass with no rising edge, and not before. Each reference must stay high and low for at least two monitor periods.
- R8: When neither reference is present, clk_out stays low and no_ref is high. no_ref falls again once either reference is present.
- R9: pri_active is high exactly when the primary gate is open (after a two-flop resync to clk_mon), and low when the secondary is routed or no reference is routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock for activity detection and control |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pri | input | 1 | Primary reference clock |
| ref_sec | input | 1 | Secondary reference clock |
| sel_pin | input | 1 | Manual source select: 1 primary, 0 secondary |
| auto_mode | input | 1 | 0 manual steering, 1 automatic failover (reset use: 0) |
| tmo_cycles | input | TW | Activity timeout in clk_mon cycles |
| clk_out | output | 1 | Selected reference clock |
| pri_active | output | 1 | High while the primary gate is open |
| no_ref | output | 1 | High while neither reference is present |

## Verification
On every monitor cycle, the assertions check the selection policy against the activity monitors' presence verdicts: manual routing, primary preference, fallback, and the forced idle state when nothing is present. They also check that the resynchronized gate states never overlap. Some behaviour only the bench scenarios can show: that clk_out really carries the edges of the chosen reference, that no runt pulse appears while the source changes (including a primary frozen high), and the timing of the timeout. The bench shows these by counting edges in windows against the reference clocks and by measuring every output pulse width.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_SEC  = 2'd2
  } src_e;

  // True once an idle count has used up the whole timeout window.
  function automatic logic window_expired(input logic [31:0] idle,
                                          input logic [31:0] limit);
    return (idle + 32'd1) >= limit;
  endfunction

  // Source choice from mode, pin and presence verdicts.
  function automatic src_e pick_source(input logic auto_en,
                                       input logic pin_pri,
                                       input logic pri_ok,
                                       input logic sec_ok);
    src_e s;
    if (!pri_ok && !sec_ok)  s = SRC_NONE;
    else if (auto_en)        s = pri_ok ? SRC_PRI : SRC_SEC;
    else                     s = pin_pri ? SRC_PRI : SRC_SEC;
    return s;
  endfunction

endpackage

// File: rtl/refsel_activity.sv
`timescale 1ns/1ps
module refsel_activity #(
  parameter int TW     = 8,
  parameter int STAGES = 3
) (
  input  logic          clk_mon,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic [TW-1:0] limit,
  output logic          present
);
  import refsel_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] samp;
  logic              rise_seen;
  logic [TW-1:0]     idle;

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) samp <= '0;
    else        samp <= {samp[LAST-1:0], ref_clk};
  end

  assign rise_seen = samp[LAST-1] & ~samp[LAST];

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      idle    <= '0;
      present <= 1'b0;
    end else if (rise_seen) begin
      idle    <= '0;
      present <= 1'b1;
    end else if (window_expired(32'(idle), 32'(limit))) begin
      present <= 1'b0;
    end else begin
      idle <= idle + 1'b1;
    end
  end

endmodule

// File: rtl/refsel_policy.sv
`timescale 1ns/1ps
module refsel_policy #(
  parameter int STAGES = 2
) (
  input  logic clk_mon,
  input  logic rst_n,
  input  logic auto_mode,
  input  logic sel_pin,
  input  logic pri_ok,
  input  logic sec_ok,
  output logic auto_s,
  output logic sel_s,
  output logic want_pri,
  output logic want_sec,
  output logic no_ref
);
  import refsel_pkg::*;

  logic [STAGES-1:0] auto_sh, sel_sh;
  src_e              pick;

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      auto_sh <= '0;
      sel_sh  <= '0;
    end else begin
      auto_sh <= {auto_sh[STAGES-2:0], auto_mode};
      sel_sh  <= {sel_sh[STAGES-2:0], sel_pin};
    end
  end

  assign auto_s = auto_sh[STAGES-1];
  assign sel_s  = sel_sh[STAGES-1];
  assign pick   = pick_source(auto_s, sel_s, pri_ok, sec_ok);

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      want_pri <= 1'b0;
      want_sec <= 1'b0;
      no_ref   <= 1'b0;
    end else begin
      want_pri <= (pick == SRC_PRI);
      want_sec <= (pick == SRC_SEC);
      no_ref   <= (pick == SRC_NONE);
    end
  end

endmodule

// File: rtl/refsel_gate.sv
`timescale 1ns/1ps
module refsel_gate #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic clr_n,
  input  logic want,
  input  logic peer_on,
  output logic on
);
  logic [STAGES-1:0] en_sh;

  // Falling-edge chain: the gate changes only while its own clock is low.
  always_ff @(negedge clk_in or negedge clr_n) begin
    if (!clr_n) en_sh <= '0;
    else        en_sh <= {en_sh[STAGES-2:0], want & ~peer_on};
  end

  assign on = en_sh[STAGES-1];

endmodule

// File: rtl/refclk_selector.sv
`timescale 1ns/1ps
module refclk_selector #(
  parameter int TW          = 8,
  parameter int MON_SYNC    = 3,
  parameter int CTRL_SYNC   = 2,
  parameter int GATE_STAGES = 2
) (
  input  logic          clk_mon,
  input  logic          rst_n,
  input  logic          ref_pri,
  input  logic          ref_sec,
  input  logic          sel_pin,
  input  logic          auto_mode,
  input  logic [TW-1:0] tmo_cycles,
  output logic          clk_out,
  output logic          pri_active,
  output logic          no_ref
);
  localparam int NREF    = 2;
  localparam int IDX_PRI = 0;
  localparam int IDX_SEC = 1;

  logic [NREF-1:0] ref_v;
  logic [NREF-1:0] pres;
  logic [NREF-1:0] want;
  logic [NREF-1:0] on;
  logic [NREF-1:0] act;
  logic            auto_s, sel_s;

  assign ref_v = {ref_sec, ref_pri};

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic act_q, act_s;

    refsel_activity #(.TW(TW), .STAGES(MON_SYNC)) u_act (
      .clk_mon (clk_mon),
      .rst_n   (rst_n),
      .ref_clk (ref_v[g]),
      .limit   (tmo_cycles),
      .present (pres[g])
    );

    // A missing reference cannot close its own gate, so presence clears it.
    refsel_gate #(.STAGES(GATE_STAGES)) u_gate (
      .clk_in  (ref_v[g]),
      .clr_n   (rst_n & pres[g]),
      .want    (want[g]),
      .peer_on (on[NREF-1-g]),
      .on      (on[g])
    );

    always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        act_s <= 1'b0;
      end else begin
        act_q <= on[g];
        act_s <= act_q;
      end
    end
    assign act[g] = act_s;
  end

  refsel_policy #(.STAGES(CTRL_SYNC)) u_policy (
    .clk_mon   (clk_mon),
    .rst_n     (rst_n),
    .auto_mode (auto_mode),
    .sel_pin   (sel_pin),
    .pri_ok    (pres[IDX_PRI]),
    .sec_ok    (pres[IDX_SEC]),
    .auto_s    (auto_s),
    .sel_s     (sel_s),
    .want_pri  (want[IDX_PRI]),
    .want_sec  (want[IDX_SEC]),
    .no_ref    (no_ref)
  );

  assign clk_out    = |(ref_v & on);
  assign pri_active = act[IDX_PRI];

endmodule

// File: rtl/refclk_selector_chk.sv
`timescale 1ns/1ps
module refclk_selector_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_s,
  input logic sel_s,
  input logic pri_pres,
  input logic sec_pres,
  input logic want_pri,
  input logic want_sec,
  input logic no_ref,
  input logic pri_act,
  input logic sec_act
);

  a_r2_manual_pri: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_s && sel_s && (pri_pres || sec_pres)) |=> (want_pri && !want_sec));

  a_r2_manual_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_s && !sel_s && (pri_pres || sec_pres)) |=> (want_sec && !want_pri));

  a_r3_auto_prefers_pri: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && pri_pres) |=> (want_pri && !want_sec));

  a_r4_auto_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && !pri_pres && sec_pres) |=> (want_sec && !want_pri));

  a_r8_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_pres && !sec_pres) |=> (no_ref && !want_pri && !want_sec));

  a_r5_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_act && sec_act));

endmodule

bind refclk_selector refclk_selector_chk u_chk (
  .clk      (clk_mon),
  .rst_n    (rst_n),
  .auto_s   (auto_s),
  .sel_s    (sel_s),
  .pri_pres (pres[0]),
  .sec_pres (pres[1]),
  .want_pri (want[0]),
  .want_sec (want[1]),
  .no_ref   (no_ref),
  .pri_act  (act[0]),
  .sec_act  (act[1])
);

// File: tb/refclk_selector_bench.sv
`timescale 1ns/1ps
module refclk_selector_bench;
  localparam int TW = 8;

  logic          clk_mon = 1'b0;
  logic          rst_n   = 1'b0;
  logic          ref_pri;
  logic          ref_sec;
  logic          sel_pin   = 1'b0;
  logic          auto_mode = 1'b0;
  logic [TW-1:0] tmo_cycles = 8'd32;
  logic          clk_out, pri_active, no_ref;

  refclk_selector #(.TW(TW)) u_refclk_selector (
    .clk_mon    (clk_mon),
    .rst_n      (rst_n),
    .ref_pri    (ref_pri),
    .ref_sec    (ref_sec),
    .sel_pin    (sel_pin),
    .auto_mode  (auto_mode),
    .tmo_cycles (tmo_cycles),
    .clk_out    (clk_out),
    .pri_active (pri_active),
    .no_ref     (no_ref)
  );

  always #2 clk_mon = ~clk_mon;   // 250 MHz

  // Primary: 40 ns period. Secondary: 48 ns period (20% slower).
  bit pri_run = 1'b1, sec_run = 1'b1, pri_lvl = 1'b0, sec_lvl = 1'b0;
  initial begin
    ref_pri = 1'b0;
    #1;
    forever begin
      ref_pri = pri_run ? ~ref_pri : pri_lvl;
      #20;
    end
  end
  initial begin
    ref_sec = 1'b0;
    #3;
    forever begin
      ref_sec = sec_run ? ~ref_sec : sec_lvl;
      #24;
    end
  end

  int      checks = 0, fails = 0, runts = 0;
  int      n_out = 0, n_pri = 0, n_sec = 0;
  bit      win = 1'b0, width_on = 1'b0, done = 1'b0;
  realtime t_last = 0.0;

  always @(posedge clk_out) if (win) n_out++;
  always @(posedge ref_pri) if (win) n_pri++;
  always @(posedge ref_sec) if (win) n_sec++;
  always @(clk_out) begin
    if (width_on && (($realtime - t_last) < 19.0)) runts++;
    t_last = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // 0 none, 1 primary, 2 secondary
  function automatic int model_src(input bit a, input bit s, input bit p, input bit q);
    if (!p && !q) return 0;
    if (a)        return p ? 1 : 2;
    return s ? 1 : 2;
  endfunction

  task automatic observe(input string req);
    int e, exp_n;
    #600;
    n_out = 0; n_pri = 0; n_sec = 0;
    win = 1'b1;
    #800;
    win = 1'b0;
    e = model_src(auto_mode, sel_pin, pri_run, sec_run);
    exp_n = (e == 1) ? n_pri : (e == 2) ? n_sec : 0;
    check(n_out == exp_n, req, "clk_out rising edges", n_out, exp_n);
    check(pri_active == (e == 1 && pri_run), "R9", "pri_active",
          int'(pri_active), int'(e == 1 && pri_run));
    check(no_ref == (e == 0), "R8", "no_ref", int'(no_ref), int'(e == 0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1D5E_C0DE);
    #0.5;
    #40;
    // R1: reset state
    check(clk_out == 1'b0, "R1", "clk_out in reset", int'(clk_out), 0);
    check(pri_active == 1'b0, "R1", "pri_active in reset", int'(pri_active), 0);
    check(no_ref == 1'b0, "R1", "no_ref in reset", int'(no_ref), 0);
    rst_n = 1'b1;
    width_on = 1'b1;

    // R2: manual steering
    sel_pin = 1'b1; observe("R2");
    sel_pin = 1'b0; observe("R2");

    // R3: automatic, both present, primary preferred
    auto_mode = 1'b1; observe("R3");

    // R4: primary lost (stuck low), then back
    pri_lvl = 1'b0; pri_run = 1'b0; observe("R4");
    pri_run = 1'b1; observe("R4");

    // R6: primary stops while high
    pri_lvl = 1'b1; pri_run = 1'b0; observe("R4");
    check(runts == 0, "R6", "runt pulses after stuck-high loss", runts, 0);
    pri_run = 1'b1; observe("R4");

    // R7 / R8: both stop; timeout must not fire early
    pri_lvl = 1'b0; sec_lvl = 1'b0; pri_run = 1'b0; sec_run = 1'b0;
    #40;
    check(no_ref == 1'b0, "R7", "no_ref before timeout", int'(no_ref), 0);
    #360;
    check(no_ref == 1'b1, "R7", "no_ref after timeout", int'(no_ref), 1);
    check(clk_out == 1'b0, "R8", "clk_out idle level", int'(clk_out), 0);
    observe("R8");
    sec_run = 1'b1; observe("R7");
    pri_run = 1'b1; observe("R3");

    // Random mix of mode, pin and reference activity
    for (int i = 0; i < 14; i++) begin
      auto_mode = 1'($urandom);
      sel_pin   = 1'($urandom);
      pri_lvl   = 1'($urandom);
      sec_lvl   = 1'($urandom);
      pri_run   = ($urandom % 4) != 0;
      sec_run   = ($urandom % 4) != 0;
      observe(auto_mode ? "R4" : "R2");
    end

    check(runts == 0, "R5 R6", "runt pulses over whole run", runts, 0);
    finish_run();
  end

endmodule